// File: doc/BRIEF.md
# Parallel Gold-Code Correlator Bank

The block correlates a stream of complex baseband samples against a fixed binary spreading template. It evaluates many candidate alignments at the same time, so that a receiver can acquire a preamble quickly. The logic clock is slow. On each clock cycle a serial-to-parallel front delivers one group of `LANES` consecutive samples. Each sample carries a signed in-phase part and a signed quadrature part. The template has `CHIPS` chips. Each chip covers `LANES` samples, so one correlation window spans `CHIPS*LANES` samples. Every template term is +1 or -1, so every term reduces to an add or a subtract and the bank needs no multiplier.

The bank holds `SUBS` sub-banks of `LANES` correlation points, one point per candidate offset. Each point keeps separate running sums for I and for Q. It reports a magnitude estimate, |I|+|Q|, saturated to `MAGW` bits. A start pulse clears every sum and opens a new window. The window closes once `SUBS+CHIPS` groups have been absorbed. At that moment a one-cycle strobe marks the results as complete, and the results then stay frozen until the next start. Peak search and any later use of the correlation belong to other blocks.

Top module: `uwb_corr_bank_top`

## Requirements
- R1: After reset, `outValid` is low and every magnitude field reads zero.
- R2: A cycle with `start` high clears every running sum, so all magnitudes read zero in the next cycle, and it opens a new window. `start` takes priority: a group presented in the same cycle is not absorbed.
- R3: The result for offset o = m*LANES + l (sub-bank m, lane l) sits in `outMag[o*MAGW +: MAGW]`. After a full window it equals min(|SI|+|SQ|, 2^MAGW-1). SI is the sum over k = 0..CHIPS*LANES-1 of t(k)*xI[o+k], and SQ is the same sum taken over xQ. t(k) is +1 when `TEMPLATE` bit floor(k/LANES) is 1, and -1 when that bit is 0.
- R4: Sample index s = g*LANES + j is lane j of the g-th absorbed group since start. Lane j occupies bits `[j*SW +: SW]` of `inI` and `inQ`, in two's complement. While a window is open, each magnitude reflects the partial sum over the samples absorbed so far.
- R5: A window closes after exactly `SUBS+CHIPS` absorbed groups. `outValid` is high in the cycle that follows the clock edge that absorbed the last group.
- R6: A cycle with `inValid` low absorbs nothing and does not advance the window.
- R7: Groups that arrive after a window has closed, or after reset but before the first start, are ignored. The magnitudes hold their values until the next start.
- R8: A magnitude whose true value is larger than 2^MAGW-1 reads exactly 2^MAGW-1.
- R9: `outValid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears all sums and opens a new window |
| inValid | input | 1 | The presented sample group is meaningful |
| inI | input | LANES*SW | In-phase samples, lane 0 is the earliest |
| inQ | input | LANES*SW | Quadrature samples, lane 0 is the earliest |
| outValid | output | 1 | One-cycle pulse when the window completes |
| outMag | output | LANES*SUBS*MAGW | Saturated magnitude for each offset |

## Verification
The bench builds the bank with 4 lanes, 3 sub-banks, a 7-chip template and 8-bit magnitudes. A complete window is then only 10 groups, and all 12 offsets can be recomputed from first principles on every clock. Because the magnitude field is narrow, ordinary full-scale samples push the sums past 255, which exercises saturation. The short window also leaves room for several restarts, stalls, start-with-data collisions and groups arriving after the window has closed.

// File: rtl/uwb_corr_pkg.sv
package uwb_corr_pkg;

  // Per-cycle commands from the control unit to the datapath.
  typedef struct packed {
    logic clearAcc;  // clear every running sum
    logic absorb;    // add the presented group into the sums
    logic finish;    // this absorbed group is the last one of the window
  } corr_strobe_t;

endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import uwb_corr_pkg::*;
#(
  parameter int GROUPS = 62,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          inValid,
  output corr_strobe_t  strb,
  output logic [CW-1:0] groupIdx,
  output logic          outValid
);

  localparam logic [CW-1:0] END_G  = CW'(GROUPS);
  localparam logic [CW-1:0] LAST_G = CW'(GROUPS - 1);

  logic [CW-1:0] grpCnt;

  always_comb begin
    strb.clearAcc = start;
    strb.absorb   = !start && inValid && (grpCnt < END_G);
    strb.finish   = strb.absorb && (grpCnt == LAST_G);
  end

  // The counter idles at END_G, so no group is taken before the first start.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpCnt   <= END_G;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.finish;
      if (start)            grpCnt <= '0;
      else if (strb.absorb) grpCnt <= grpCnt + 1'b1;
    end
  end

  assign groupIdx = grpCnt;

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R5
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(inValid) && !$past(start)));

  // R7
  group_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    groupIdx <= END_G);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !inValid) |=> $stable(groupIdx));

endmodule

// File: rtl/corr_point.sv
module corr_point
  import uwb_corr_pkg::*;
#(
  parameter int LANES = 20,
  parameter int CHIPS = 31,
  parameter int SW    = 5,
  parameter int AW    = 15,
  parameter int MAGW  = 12,
  parameter int CW    = 6,
  parameter int SUB   = 0,
  parameter int LANE  = 0,
  parameter logic [CHIPS-1:0] TEMPLATE = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  corr_strobe_t          strb,
  input  logic [CW-1:0]         groupIdx,
  input  logic [LANES*SW-1:0]   inI,
  input  logic [LANES*SW-1:0]   inQ,
  output logic [MAGW-1:0]       mag
);

  localparam int CIW = (CHIPS > 1) ? $clog2(CHIPS) : 1;
  localparam int LIM = CHIPS * LANES * (1 << (SW - 1));
  localparam logic [AW:0] CAP = (AW+1)'((1 << MAGW) - 1);

  logic signed [AW-1:0] accI, accQ, dI, dQ, extI, extQ;
  logic [SW-1:0]        laneI, laneQ;
  logic [AW-1:0]        absI, absQ;
  logic [AW:0]          total;
  int                   rel, idx;

  // Lanes at or beyond this point's lane offset belong to chip (group - SUB).
  // Lanes before it still belong to the previous chip.
  always_comb begin
    dI    = '0;
    dQ    = '0;
    idx   = 0;
    laneI = '0;
    laneQ = '0;
    extI  = '0;
    extQ  = '0;
    rel   = int'(groupIdx) - SUB;
    for (int j = 0; j < LANES; j++) begin
      idx   = (j >= LANE) ? rel : rel - 1;
      laneI = inI[j*SW +: SW];
      laneQ = inQ[j*SW +: SW];
      extI  = {{(AW-SW){laneI[SW-1]}}, laneI};
      extQ  = {{(AW-SW){laneQ[SW-1]}}, laneQ};
      if (strb.absorb && idx >= 0 && idx < CHIPS) begin
        if (TEMPLATE[idx[CIW-1:0]]) begin
          dI = dI + extI;
          dQ = dQ + extQ;
        end else begin
          dI = dI - extI;
          dQ = dQ - extQ;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAcc) begin
      accI <= '0;
      accQ <= '0;
    end else if (strb.absorb) begin
      accI <= accI + dI;
      accQ <= accQ + dQ;
    end
  end

  always_comb begin
    absI  = accI[AW-1] ? AW'(-accI) : AW'(accI);
    absQ  = accQ[AW-1] ? AW'(-accQ) : AW'(accQ);
    total = {1'b0, absI} + {1'b0, absQ};
    mag   = (total > CAP) ? CAP[MAGW-1:0] : total[MAGW-1:0];
  end

  // R3
  acc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(accI) <= LIM) && (int'(accI) >= -LIM) &&
    (int'(accQ) <= LIM) && (int'(accQ) >= -LIM));

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAcc |=> (mag == '0));

endmodule

// File: rtl/corr_bank.sv
module corr_bank
  import uwb_corr_pkg::*;
#(
  parameter int LANES = 20,
  parameter int SUBS  = 31,
  parameter int CHIPS = 31,
  parameter int SW    = 5,
  parameter int AW    = 15,
  parameter int MAGW  = 12,
  parameter int CW    = 6,
  parameter logic [CHIPS-1:0] TEMPLATE = '1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  corr_strobe_t                strb,
  input  logic [CW-1:0]               groupIdx,
  input  logic [LANES*SW-1:0]         inI,
  input  logic [LANES*SW-1:0]         inQ,
  output logic [LANES*SUBS*MAGW-1:0]  magBus
);

  for (genvar gm = 0; gm < SUBS; gm++) begin : g_sub
    for (genvar gl = 0; gl < LANES; gl++) begin : g_pt
      localparam int OFS = gm * LANES + gl;
      corr_point #(
        .LANES(LANES), .CHIPS(CHIPS), .SW(SW), .AW(AW), .MAGW(MAGW),
        .CW(CW), .SUB(gm), .LANE(gl), .TEMPLATE(TEMPLATE)
      ) u_pt (
        .clk      (clk),
        .rstN     (rstN),
        .strb     (strb),
        .groupIdx (groupIdx),
        .inI      (inI),
        .inQ      (inQ),
        .mag      (magBus[OFS*MAGW +: MAGW])
      );
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.absorb && !strb.clearAcc) |=> $stable(magBus));

endmodule

// File: rtl/uwb_corr_bank_top.sv
module uwb_corr_bank_top
  import uwb_corr_pkg::*;
#(
  parameter int LANES = 20,
  parameter int SUBS  = 31,
  parameter int CHIPS = 31,
  parameter int SW    = 5,
  parameter int MAGW  = 12,
  parameter logic [CHIPS-1:0] TEMPLATE = 31'h4B3A9D15
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        inValid,
  input  logic [LANES*SW-1:0]         inI,
  input  logic [LANES*SW-1:0]         inQ,
  output logic                        outValid,
  output logic [LANES*SUBS*MAGW-1:0]  outMag
);

  localparam int TAPS   = CHIPS * LANES;
  localparam int GROUPS = SUBS + CHIPS;
  localparam int PEAK   = TAPS * (1 << (SW - 1));
  localparam int AW     = $clog2(PEAK + 1) + 1;
  localparam int CW     = $clog2(GROUPS + 1);

  corr_strobe_t  strb;
  logic [CW-1:0] groupIdx;

  corr_ctrl #(.GROUPS(GROUPS), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .strb     (strb),
    .groupIdx (groupIdx),
    .outValid (outValid)
  );

  corr_bank #(
    .LANES(LANES), .SUBS(SUBS), .CHIPS(CHIPS), .SW(SW), .AW(AW),
    .MAGW(MAGW), .CW(CW), .TEMPLATE(TEMPLATE)
  ) u_bank (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .groupIdx (groupIdx),
    .inI      (inI),
    .inQ      (inQ),
    .magBus   (outMag)
  );

endmodule

// File: tb/uwb_corr_bank_top_tb_top.sv
module uwb_corr_bank_top_tb_top;

  localparam int L    = 4;
  localparam int M    = 3;
  localparam int C    = 7;
  localparam int SW   = 5;
  localparam int MW   = 8;
  localparam logic [C-1:0] TPL = 7'b1011001;
  localparam int N    = C * L;
  localparam int OFFS = L * M;
  localparam int T    = M + C;
  localparam int NS   = T * L;
  localparam int CAP  = (1 << MW) - 1;

  logic              clk = 1'b0;
  logic              rstN, start, inValid, outValid;
  logic [L*SW-1:0]   inI, inQ;
  logic [OFFS*MW-1:0] outMag;

  uwb_corr_bank_top #(
    .LANES(L), .SUBS(M), .CHIPS(C), .SW(SW), .MAGW(MW), .TEMPLATE(TPL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inI(inI), .inQ(inQ), .outValid(outValid), .outMag(outMag)
  );

  always #2 clk = ~clk;

  int  tests = 0;
  int  fails = 0;
  int  sI[NS];
  int  sQ[NS];
  int  curI[L];
  int  curQ[L];
  int  cnt = T;      // absorbed groups; T means no window is open
  bit  expValid = 0;
  bit  done = 0;

  // Reference: partial correlation over the samples absorbed so far.
  function automatic int refMag(int o);
    int ai = 0;
    int aq = 0;
    int m;
    for (int s = o; s < o + N; s++) begin
      if (s < cnt * L) begin
        if (TPL[(s - o) / L]) begin ai += sI[s]; aq += sQ[s]; end
        else                  begin ai -= sI[s]; aq -= sQ[s]; end
      end
    end
    m = (ai < 0 ? -ai : ai) + (aq < 0 ? -aq : aq);
    return (m > CAP) ? CAP : m;
  endfunction

  task automatic checkNow(string tag);
    int bad = -1;
    int got = 0;
    int ex = 0;
    tests++;
    if (outValid !== expValid) begin
      fails++;
      $display("FAIL R5 R9 outValid got %0b expected %0b", outValid, expValid);
    end
    tests++;
    for (int o = 0; o < OFFS; o++) begin
      if (bad < 0 && int'(outMag[o*MW +: MW]) != refMag(o)) begin
        bad = o;
        got = int'(outMag[o*MW +: MW]);
        ex  = refMag(o);
      end
    end
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s offset %0d magnitude got %0d expected %0d", tag, bad, got, ex);
    end
  endtask

  // Check the state left by the previous edge, then present the next inputs.
  task automatic step(bit st, bit v, string tag);
    @(negedge clk);
    checkNow(tag);
    start   = st;
    inValid = v;
    for (int j = 0; j < L; j++) begin
      inI[j*SW +: SW] = SW'(curI[j]);
      inQ[j*SW +: SW] = SW'(curQ[j]);
    end
    expValid = !st && v && (cnt == T - 1);
    if (st) cnt = 0;
    else if (v && cnt < T) begin
      for (int j = 0; j < L; j++) begin
        sI[cnt*L + j] = curI[j];
        sQ[cnt*L + j] = curQ[j];
      end
      cnt++;
    end
  endtask

  task automatic randGroup();
    for (int j = 0; j < L; j++) begin
      curI[j] = int'($urandom_range(31)) - 16;
      curQ[j] = int'($urandom_range(31)) - 16;
    end
  endtask

  task automatic fillGroup(int vi, int vq);
    for (int j = 0; j < L; j++) begin
      curI[j] = vi;
      curQ[j] = vq;
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin sI[s] = 0; sQ[s] = 0; end
    fillGroup(0, 0);
    rstN = 1'b0; start = 1'b0; inValid = 1'b0; inI = '0; inQ = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    step(0, 0, "R1");
    step(0, 0, "R1");
    // R7: groups before any start are not absorbed
    randGroup(); step(0, 1, "R7");
    randGroup(); step(0, 1, "R7");

    // R2 R4 R6: random window with stalls
    step(1, 0, "R2");
    while (cnt < T) begin
      bit v = ($urandom_range(3) != 0);
      randGroup();
      step(0, v, v ? "R4" : "R6");
    end
    fillGroup(0, 0);
    step(0, 0, "R3 R5");
    // R7: groups after the window closed are ignored
    randGroup(); step(0, 1, "R7");
    randGroup(); step(0, 1, "R7");
    step(0, 0, "R7");

    // R2: start collides with data, then restart in mid window
    randGroup(); step(1, 1, "R2");
    randGroup(); step(0, 0, "R2");
    for (int g = 0; g < 4; g++) begin randGroup(); step(0, 1, "R4"); end
    randGroup(); step(1, 1, "R2");
    while (cnt < T) begin randGroup(); step(0, 1, "R4"); end
    step(0, 0, "R3 R5");

    // R8: template-matched full-scale burst saturates the aligned offset
    step(1, 0, "R2");
    while (cnt < T) begin
      for (int j = 0; j < L; j++) begin
        int s = cnt * L + j;
        int v = (s < N) ? (TPL[s / L] ? 15 : -16) : 0;
        curI[j] = v;
        curQ[j] = v;
      end
      step(0, 1, "R8");
    end
    step(0, 0, "R8");

    // R3: most negative sample code everywhere
    step(1, 0, "R2");
    fillGroup(-16, -16);
    while (cnt < T) step(0, 1, "R3");
    step(0, 0, "R3 R5");
    step(0, 0, "R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule